// File: doc/BRIEF.md
# Locked Bus Arbiter for Atomic Memory Operations

This block lets two to four processor ports share one memory port. Each port presents a request with a valid/ready handshake, a two-bit command, an address, write data and a lock flag. Unlocked requests are served round-robin. A transfer is complete in the cycle in which its port sees ready. The memory model answers reads in the same cycle. So a plain read or a plain write needs one cycle and is atomic by itself.

Read-modify-write needs more than one bus phase. A port keeps the bus through such a sequence by raising its lock flag on the read phase. From then on no other port is granted until the owner completes a write phase. The bus is arbitrated afresh in the next cycle.

The exchange command takes the bus for two memory cycles without any lock flag. In the first cycle it reads the old word. In the second it writes the new word and hands the old word back to the requester in the same handshake.

Top module: `lock_bus_arbiter`

## Requirements
- R1: Out of reset, and in any cycle with no valid request, no ready is raised and the memory enable is low.
- R2: At most one port sees ready in a cycle, and every ready is accompanied by an enabled memory access.
- R3: Unlocked contending requests are granted in cyclic port order, starting with the port after the most recent grantee. After reset the most recent grantee counts as the highest-numbered port.
- R4: A read (command 2'b00) returns the word stored at its address on rsp_rdata in its ready cycle. A write (command 2'b01) stores its data at its address.
- R5: For the read-modify-write command (2'b10), a port's handshakes alternate between a read phase and a write phase. The read phase comes first and drives mem_we low. The write phase drives mem_we high and stores the data.
- R6: After a read-type handshake made with the lock flag high, every other port is held off (ready low) until the owner finishes a write-type handshake.
- R7: In the cycle after the lock-releasing write, arbitration resumes round-robin from the owner.
- R8: An exchange (command 2'b11) takes two cycles. The first is a memory read with ready low. The second writes the new data to the same address with ready high, returns the old word, and admits no other port.
- R9: Without the lock flag, the two phases of a read-modify-write may be separated by another port's transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_cmd | input | 2*NPORTS | Command per port: 00 read, 01 write, 10 read-modify-write, 11 exchange |
| req_lock | input | NPORTS | Lock flag per port |
| req_addr | input | AW*NPORTS | Address per port, port i in lane i |
| req_wdata | input | DW*NPORTS | Write data per port |
| req_ready | output | NPORTS | Handshake completes when ready and valid are both high |
| rsp_rdata | output | DW | Read data for the port seeing ready |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |

## Verification
A random mix of plain reads and writes arrives from all ports with random timing and addresses drawn from a small range. It exercises fairness and data flow together: a wrong rotation shows up as a mismatched ready, and a misrouted lane shows up as wrong data. Directed sequences then cover three cases. A locked read-modify-write runs while competitors wait, which separates real lock holding from simple round-robin luck. An unlocked read-modify-write is interleaved with another port, which shows that the lock flag, not the command, holds the bus. An exchange is made while a competitor is pending, which shows the two-cycle hold and the return of the old word.

// File: rtl/lba_pkg.sv
package lba_pkg;
   typedef enum logic [1:0] {
      CMD_RD  = 2'b00,
      CMD_WR  = 2'b01,
      CMD_RMW = 2'b10,
      CMD_SWP = 2'b11
   } lba_cmd_e;
endpackage

// File: rtl/lba_rr_pick.sv
module lba_rr_pick #(
   parameter int NPORTS = 4,
   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic [NPORTS-1:0] req,
   input  logic [IW-1:0]     last,
   output logic              hit,
   output logic [IW-1:0]     idx
);
   generate
      if (NPORTS == 2) begin : g_two
         always_comb begin
            hit = |req;
            idx = ~last;
            if (!req[~last] && req[last]) idx = last;
         end
      end else begin : g_many
         always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int k = 1; k <= NPORTS; k++) begin
               int c;
               c = (int'(last) + k) % NPORTS;
               if (!hit && req[c]) begin
                  hit = 1'b1;
                  idx = IW'(c);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/lba_lane_sel.sv
module lba_lane_sel #(
   parameter int NPORTS = 4,
   parameter int AW = 8,
   parameter int DW = 16,
   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic [2*NPORTS-1:0]  cmd_flat,
   input  logic [AW*NPORTS-1:0] addr_flat,
   input  logic [DW*NPORTS-1:0] wdata_flat,
   input  logic [NPORTS-1:0]    lock_vec,
   input  logic [IW-1:0]        sel,
   output logic [1:0]           s_cmd,
   output logic [AW-1:0]        s_addr,
   output logic [DW-1:0]        s_wdata,
   output logic                 s_lock
);
   logic [1:0]    cmd_l   [NPORTS];
   logic [AW-1:0] addr_l  [NPORTS];
   logic [DW-1:0] wdata_l [NPORTS];

   for (genvar i = 0; i < NPORTS; i++) begin : g_lane
      assign cmd_l[i]   = cmd_flat[i*2 +: 2];
      assign addr_l[i]  = addr_flat[i*AW +: AW];
      assign wdata_l[i] = wdata_flat[i*DW +: DW];
   end

   assign s_cmd   = cmd_l[sel];
   assign s_addr  = addr_l[sel];
   assign s_wdata = wdata_l[sel];
   assign s_lock  = lock_vec[sel];
endmodule

// File: rtl/lba_lock_ctrl.sv
module lba_lock_ctrl #(
   parameter int NPORTS = 4,
   parameter int DW = 16,
   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs,
   input  logic [IW-1:0]     sel,
   input  logic              sel_wr,
   input  logic              sel_lock,
   input  logic              sel_rmw,
   input  logic              swp_start,
   input  logic [DW-1:0]     mem_rdata,
   output logic              lock_act,
   output logic [IW-1:0]     lock_own,
   output logic              swp_wr,
   output logic [DW-1:0]     swp_buf,
   output logic [IW-1:0]     last,
   output logic [NPORTS-1:0] phase
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_act <= 1'b0;
         lock_own <= '0;
         swp_wr   <= 1'b0;
         swp_buf  <= '0;
         last     <= IW'(NPORTS - 1);
         phase    <= '0;
      end else begin
         if (swp_start) begin
            swp_wr   <= 1'b1;
            lock_own <= sel;
            swp_buf  <= mem_rdata;
         end
         if (hs) begin
            last <= sel;
            if (swp_wr) swp_wr <= 1'b0;
            if (sel_wr) begin
               lock_act <= 1'b0;
            end else if (sel_lock) begin
               lock_act <= 1'b1;
               lock_own <= sel;
            end
            if (sel_rmw) phase[sel] <= ~phase[sel];
         end
      end
   end
endmodule

// File: rtl/lock_bus_arbiter.sv
module lock_bus_arbiter
   import lba_pkg::*;
#(
   parameter int NPORTS = 4,
   parameter int AW = 8,
   parameter int DW = 16,
   localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPORTS-1:0]    req_valid,
   input  logic [2*NPORTS-1:0]  req_cmd,
   input  logic [NPORTS-1:0]    req_lock,
   input  logic [AW*NPORTS-1:0] req_addr,
   input  logic [DW*NPORTS-1:0] req_wdata,
   output logic [NPORTS-1:0]    req_ready,
   output logic [DW-1:0]        rsp_rdata,
   output logic                 mem_en,
   output logic                 mem_we,
   output logic [AW-1:0]        mem_addr,
   output logic [DW-1:0]        mem_wdata,
   input  logic [DW-1:0]        mem_rdata
);
   if (NPORTS < 2 || NPORTS > 4) begin : g_bad_ports
      $error("lock_bus_arbiter: NPORTS must be 2..4");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("lock_bus_arbiter: AW and DW must be positive");
   end

   logic              lock_act, swp_wr;
   logic [IW-1:0]     lock_own, last, pidx, sel;
   logic [DW-1:0]     swp_buf;
   logic [NPORTS-1:0] phase, elig, own_mask;
   logic              hit, go, hs, swp_start, sel_wr, sel_rmw, rmw_wr;
   logic [1:0]        s_cmd;
   logic [AW-1:0]     s_addr;
   logic [DW-1:0]     s_wdata;
   logic              s_lock;

   assign own_mask = NPORTS'(1) << lock_own;
   assign elig     = (lock_act || swp_wr) ? (req_valid & own_mask) : req_valid;

   lba_rr_pick #(.NPORTS(NPORTS)) u_pick (
      .req  (elig),
      .last (last),
      .hit  (hit),
      .idx  (pidx)
   );

   assign sel = swp_wr ? lock_own : pidx;
   assign go  = swp_wr ? req_valid[lock_own] : hit;

   lba_lane_sel #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_lane (
      .cmd_flat   (req_cmd),
      .addr_flat  (req_addr),
      .wdata_flat (req_wdata),
      .lock_vec   (req_lock),
      .sel        (sel),
      .s_cmd      (s_cmd),
      .s_addr     (s_addr),
      .s_wdata    (s_wdata),
      .s_lock     (s_lock)
   );

   assign sel_rmw   = (s_cmd == CMD_RMW);
   assign rmw_wr    = sel_rmw && phase[sel];
   assign swp_start = go && !swp_wr && (s_cmd == CMD_SWP);
   assign hs        = go && !swp_start;
   assign sel_wr    = swp_wr || rmw_wr || (s_cmd == CMD_WR);

   always_comb begin
      req_ready = '0;
      if (hs) req_ready[sel] = 1'b1;
   end

   assign mem_en    = go;
   assign mem_we    = go && sel_wr;
   assign mem_addr  = s_addr;
   assign mem_wdata = s_wdata;
   assign rsp_rdata = swp_wr ? swp_buf : mem_rdata;

   lba_lock_ctrl #(.NPORTS(NPORTS), .DW(DW)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs        (hs),
      .sel       (sel),
      .sel_wr    (sel_wr),
      .sel_lock  (s_lock),
      .sel_rmw   (sel_rmw),
      .swp_start (swp_start),
      .mem_rdata (mem_rdata),
      .lock_act  (lock_act),
      .lock_own  (lock_own),
      .swp_wr    (swp_wr),
      .swp_buf   (swp_buf),
      .last      (last),
      .phase     (phase)
   );
endmodule

// File: rtl/lba_chk.sv
module lba_chk #(
   parameter int NPORTS = 4,
   parameter int AW = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NPORTS-1:0]   req_valid,
   input logic [NPORTS-1:0]   req_lock,
   input logic [NPORTS-1:0]   req_ready,
   input logic                mem_en,
   input logic                mem_we,
   input logic [AW-1:0]       mem_addr
);
   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == '0) |-> (req_ready == '0 && !mem_en));

   // R2
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready));

   // R2
   grant_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready != '0) |-> mem_en);

   // R8
   swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we && req_ready == '0) |=>
      (mem_en && mem_we && $countones(req_ready) == 1 && mem_addr == $past(mem_addr)));

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      // R6
      lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_ready[p] && req_valid[p] && req_lock[p] && !mem_we) |=>
         ((req_ready & ~(NPORTS'(1) << p)) == '0));
   end
endmodule

bind lock_bus_arbiter lba_chk #(.NPORTS(NPORTS), .AW(AW)) u_lba_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_lock  (req_lock),
   .req_ready (req_ready),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/test_lock_bus_arbiter.sv
module test_lock_bus_arbiter;
   localparam int N  = 4;
   localparam int AW = 8;
   localparam int DW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          v [N];
   logic [1:0]    c [N];
   logic          l [N];
   logic [AW-1:0] a [N];
   logic [DW-1:0] w [N];

   logic [N-1:0]    req_valid, req_lock, req_ready;
   logic [2*N-1:0]  req_cmd;
   logic [AW*N-1:0] req_addr;
   logic [DW*N-1:0] req_wdata;
   logic [DW-1:0]   rsp_rdata, mem_wdata, mem_rdata;
   logic [AW-1:0]   mem_addr;
   logic            mem_en, mem_we;

   always_comb begin
      for (int p = 0; p < N; p++) begin
         req_valid[p]          = v[p];
         req_lock[p]           = l[p];
         req_cmd[p*2 +: 2]     = c[p];
         req_addr[p*AW +: AW]  = a[p];
         req_wdata[p*DW +: DW] = w[p];
      end
   end

   logic [DW-1:0] mem [2**AW];
   assign mem_rdata = mem[mem_addr];
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 2**AW; i++) mem[i] <= DW'(i * 7 + 256);
      end else if (mem_en && mem_we) begin
         mem[mem_addr] <= mem_wdata;
      end
   end

   lock_bus_arbiter #(.NPORTS(N), .AW(AW), .DW(DW)) i_lock_bus_arbiter (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_lock(req_lock), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ready(req_ready), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   logic [DW-1:0] sh [2**AW];
   int exp_last = N - 1;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   function automatic int rr(input logic [N-1:0] vv, input int last);
      for (int k = 1; k <= N; k++) begin
         if (vv[(last + k) % N]) return (last + k) % N;
      end
      return -1;
   endfunction

   task automatic idle();
      for (int p = 0; p < N; p++) begin
         v[p] = 1'b0; l[p] = 1'b0; c[p] = 2'b00; a[p] = '0; w[p] = '0;
      end
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic put(input int p, input logic [1:0] cm, input logic lk,
                      input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      v[p] = 1'b1; c[p] = cm; l[p] = lk; a[p] = ad; w[p] = wd;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] old;
      void'($urandom(32'd1234));
      for (int i = 0; i < 2**AW; i++) sh[i] = DW'(i * 7 + 256);
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: quiet after reset
      chk("R1 ready", 32'(req_ready), 32'h0);
      chk("R1 mem_en", 32'(mem_en), 32'h0);
      nxt();

      // R3, R4: all ports reading continuously
      for (int p = 0; p < N; p++) put(p, 2'b00, 1'b0, AW'(p + 1), '0);
      for (int k = 0; k < 5; k++) begin
         int g;
         g = rr(4'b1111, exp_last);
         #2;
         chk("R3 rotation", 32'(req_ready), 32'(1 << g));
         chk("R4 read data", 32'(rsp_rdata), 32'(sh[g + 1]));
         exp_last = g;
         nxt();
      end
      idle();

      // R4: write then read back
      put(2, 2'b01, 1'b0, 8'h20, 16'hA5A5);
      #2; chk("R4 write grant", 32'(req_ready), 32'h4);
      sh[8'h20] = 16'hA5A5; nxt(); idle();
      put(1, 2'b00, 1'b0, 8'h20, '0);
      #2; chk("R4 readback", 32'(rsp_rdata), 32'hA5A5);
      nxt(); idle();

      // R5, R6, R7: locked read-modify-write by port 1
      put(1, 2'b10, 1'b1, 8'h05, '0);
      #2;
      chk("R5 rmw read grant", 32'(req_ready), 32'h2);
      chk("R5 rmw read phase", 32'(mem_we), 32'h0);
      chk("R5 rmw old data", 32'(rsp_rdata), 32'(sh[5]));
      old = rsp_rdata;
      nxt();
      v[1] = 1'b0;
      put(0, 2'b00, 1'b0, 8'h05, '0);
      put(2, 2'b00, 1'b0, 8'h05, '0);
      for (int k = 0; k < 2; k++) begin
         #2; chk("R6 others stalled", 32'(req_ready), 32'h0);
         nxt();
      end
      put(1, 2'b10, 1'b1, 8'h05, old + 16'd3);
      #2;
      chk("R6 owner write grant", 32'(req_ready), 32'h2);
      chk("R5 rmw write phase", 32'(mem_we), 32'h1);
      sh[5] = old + 16'd3;
      nxt();
      v[1] = 1'b0; l[1] = 1'b0;
      #2;
      chk("R7 rearbitrate after owner", 32'(req_ready), 32'h4);
      chk("R7 modified word", 32'(rsp_rdata), 32'(sh[5]));
      nxt(); v[2] = 1'b0;
      #2; chk("R7 next in turn", 32'(req_ready), 32'h1);
      nxt(); idle();
      exp_last = 0;

      // R9: unlocked read-modify-write split by another port
      put(3, 2'b10, 1'b0, 8'h07, '0);
      #2; chk("R9 rmw read grant", 32'(req_ready), 32'h8);
      nxt(); idle();
      put(0, 2'b01, 1'b0, 8'h07, 16'h1234);
      #2; chk("R9 interleaved write", 32'(req_ready), 32'h1);
      nxt(); idle();
      put(3, 2'b10, 1'b0, 8'h07, 16'h5555);
      #2;
      chk("R9 rmw write grant", 32'(req_ready), 32'h8);
      chk("R5 second phase writes", 32'(mem_we), 32'h1);
      sh[7] = 16'h5555;
      nxt(); idle();
      put(0, 2'b00, 1'b0, 8'h07, '0);
      #2; chk("R9 final word", 32'(rsp_rdata), 32'h5555);
      nxt(); idle();

      // R8: exchange with a competitor pending
      put(2, 2'b11, 1'b0, 8'h09, 16'hBEEF);
      #2;
      chk("R8 first cycle ready", 32'(req_ready), 32'h0);
      chk("R8 first cycle read", 32'({mem_en, mem_we}), 32'h2);
      nxt();
      put(0, 2'b00, 1'b0, 8'h09, '0);
      #2;
      chk("R8 second cycle grant", 32'(req_ready), 32'h4);
      chk("R8 write", 32'(mem_we), 32'h1);
      chk("R8 old word", 32'(rsp_rdata), 32'(sh[9]));
      sh[9] = 16'hBEEF;
      nxt(); v[2] = 1'b0;
      #2;
      chk("R8 competitor next", 32'(req_ready), 32'h1);
      chk("R8 new word stored", 32'(rsp_rdata), 32'hBEEF);
      nxt(); idle();
      exp_last = 0;

      // R2, R3, R4: random plain traffic
      for (int t = 0; t < 3000; t++) begin
         logic [N-1:0] vv;
         int g;
         for (int p = 0; p < N; p++) begin
            if (!v[p] && ($urandom % 2 == 0)) begin
               put(p, ($urandom % 2 == 0) ? 2'b00 : 2'b01, 1'b0,
                   AW'($urandom % 16), DW'($urandom));
            end
            vv[p] = v[p];
         end
         g = rr(vv, exp_last);
         #2;
         if (g < 0) begin
            chk("R1 no grant", 32'(req_ready), 32'h0);
         end else begin
            chk("R3 random grant", 32'(req_ready), 32'(1 << g));
            if (c[g] == 2'b00) chk("R4 random read", 32'(rsp_rdata), 32'(sh[a[g]]));
            else sh[a[g]] = w[g];
            exp_last = g;
         end
         nxt();
         if (g >= 0) v[g] = 1'b0;
      end
      idle();
      nxt();

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule